// File: doc/BRIEF.md
# Pixel to Bus-Cycle Packer

The packer takes pixels of 12, 16, 18 or 24 bits from a ready/valid stream and cuts each one into the words a narrow parallel display bus carries. The bus is 8, 9, 12 or 16 lines wide. A frame starts with a one-cycle `frame_start`. At that moment the packer samples the pixel size, the bus width and the cycle format. It checks that the three agree, and it loads the frame's pixel count, which is width times height. Words leave on a second ready/valid port toward the strobe timing engine. The most significant slice of a pixel always leaves first.

Four cycle formats exist: one word per pixel, two words per pixel, three words per pixel, and three words per two pixels. The last one splits a pixel pair across three words. The middle word carries the low half of the first pixel next to the high half of the second. When every pixel of the frame has left as words, the packer raises a one-cycle `frame_done`. A configuration that fits no format, or one that names the wrong format, starts no frame and sets a sticky error flag.

Top module: `pixel_bus_packer`

## Requirements
- R1: While and after reset, and before the first frame start, `word_valid`, `pix_ready`, `frame_done` and `cfg_err` are low.
- R2: Pixel size, bus width and format are sampled only on a cycle with `frame_start` high. Pixel size codes are 0 = 12, 1 = 16, 2 = 18, 3 = 24 bits. Bus width codes are 0 = 8, 1 = 9, 2 = 12, 3 = 16 lines. Format codes are 0 = 1 word/pixel, 1 = 2 words/pixel, 2 = 3 words/pixel, 3 = 3 words/2 pixels. A change of these inputs during a frame has no effect on the words of that frame.
- R3: The accepted pairs are as follows. Pixel size 12 with width 12 uses format 0. Pixel size 16 with width 16 uses format 0. Pixel size 16 with width 8, 18 with width 9, and 24 with width 12 use format 1. Pixel size 24 with width 8 uses format 2. Pixel size 12 with width 8, 18 with width 12, and 24 with width 16 use format 3. A start with any other pair, or with a format code that differs, sets `cfg_err`. The flag stays set until reset. Such a start begins no frame, emits no word, leaves `pix_ready` low and does not disturb words already queued.
- R4: In format 0, each pixel gives one word equal to its low L bits, where L is the bus width.
- R5: In formats 1 and 2, a pixel of N·L bits gives N words, most significant slice first. For example, 24 bits on 8 lines gives bits 23:16, then 15:8, then 7:0, and 16 bits on 8 lines gives the high byte and then the low byte.
- R6: In format 3, with H = L/2, pixels pair up as A then B. Word 1 is A's top L bits. Word 2 carries A's low H bits in its upper half (bits L-1:H) and B's top H bits in bits H-1:0. Word 3 is B's low L bits. Word 1 is issued as soon as A is accepted.
- R7: In format 3, if the frame's last pixel is a first-of-pair, it gives two words. The second word holds A's low H bits in its upper half and zeros in its lower half. No third word follows.
- R8: Bits of `word_data` at and above L are zero. Pixel bits at and above the pixel size have no effect.
- R9: While `word_valid` is high and `word_ready` is low, the word stays valid and unchanged, unless a valid frame start flushes it.
- R10: `pix_ready` is high exactly when the frame still has pixels to accept, `frame_start` is low, and either no word is queued or only one is queued and `word_ready` is high.
- R11: Only the programmed number of pixels is accepted per frame. `frame_done` is high for one cycle, in the cycle after the handshake of the frame's last word. With a count of zero, it is high in the cycle after the start.
- R12: A valid frame start during a frame discards that frame's queued words and pending half-pixel, reloads the count and begins the new frame. The discarded frame gives no `frame_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dtype | input | 2 | Pixel size code |
| cfg_lines | input | 2 | Bus width code |
| cfg_fmt | input | 2 | Cycle format code |
| frame_pixels | input | CNT_W (22) | Pixels in the frame, sampled at start |
| frame_start | input | 1 | One-cycle frame start |
| pix_valid | input | 1 | Pixel offered |
| pix_data | input | PIX_W (24) | Pixel, right-aligned |
| pix_ready | output | 1 | Pixel taken when high with `pix_valid` |
| word_valid | output | 1 | Bus word available |
| word_data | output | BUS_W (16) | Bus word, right-aligned |
| word_ready | input | 1 | Downstream takes the word |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
Some properties are checked on every cycle. The error flag never drops once set. A pixel is accepted only while the frame has count left. `frame_done` only appears with no frame in progress. A stalled word holds steady. Word bits above the bus width stay zero. `pix_ready` is never high while a word is stalled.

Other behaviour can only be shown by the bench's scenarios. These cover the slice order and content in every format, the zero padding of an odd final pixel in the 3:2 format, and the exact cycle of `frame_done`. They also cover rejection of bad pairs, the ignoring of configuration changes in mid-frame, and flushing on restart. The bench shows these by comparing every handshaked word against a behavioural model under random stalls on both ports.

// File: rtl/pxpk_pkg.sv
package pxpk_pkg;

  typedef enum logic [1:0] {
    FMT_ONE   = 2'd0,
    FMT_TWO   = 2'd1,
    FMT_THREE = 2'd2,
    FMT_HALF  = 2'd3
  } fmt_e;

  // Returns {legal, format} for a pixel size code and a bus width code.
  function automatic logic [2:0] legal_fmt(input logic [1:0] dtype, input logic [1:0] lines);
    logic [2:0] r;
    r = 3'b000;
    case ({dtype, lines})
      4'b00_00: r = {1'b1, FMT_HALF};   // 12 on 8
      4'b00_10: r = {1'b1, FMT_ONE};    // 12 on 12
      4'b01_00: r = {1'b1, FMT_TWO};    // 16 on 8
      4'b01_11: r = {1'b1, FMT_ONE};    // 16 on 16
      4'b10_01: r = {1'b1, FMT_TWO};    // 18 on 9
      4'b10_10: r = {1'b1, FMT_HALF};   // 18 on 12
      4'b11_00: r = {1'b1, FMT_THREE};  // 24 on 8
      4'b11_10: r = {1'b1, FMT_TWO};    // 24 on 12
      4'b11_11: r = {1'b1, FMT_HALF};   // 24 on 16
      default:  r = 3'b000;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pxpk_cfg.sv
module pxpk_cfg
  import pxpk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_start,
  input  logic [1:0] cfg_dtype,
  input  logic [1:0] cfg_lines,
  input  logic [1:0] cfg_fmt,
  output logic       start_ok,
  output logic [1:0] lat_lines,
  output fmt_e       lat_fmt,
  output logic       cfg_err
);

  logic [2:0] verdict;

  always_comb begin
    verdict  = legal_fmt(cfg_dtype, cfg_lines);
    start_ok = frame_start && verdict[2] && (verdict[1:0] == cfg_fmt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_lines <= 2'd0;
      lat_fmt   <= FMT_ONE;
      cfg_err   <= 1'b0;
    end else begin
      if (start_ok) begin
        lat_lines <= cfg_lines;
        lat_fmt   <= fmt_e'(cfg_fmt);
      end
      if (frame_start && !start_ok)
        cfg_err <= 1'b1;
    end
  end

  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst) cfg_err |=> cfg_err)
    else $error("cfg_err dropped without reset");

endmodule

// File: rtl/pxpk_frame.sv
module pxpk_frame #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_ok,
  input  logic [CNT_W-1:0] frame_pixels,
  input  logic             pix_fire,
  input  logic             tail_pop,
  output logic             active,
  output logic             last_pix,
  output logic             frame_done
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] remaining;

  always_comb begin
    active   = (remaining != '0);
    last_pix = (remaining == ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining  <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= tail_pop || (start_ok && (frame_pixels == '0));
      if (start_ok)
        remaining <= frame_pixels;
      else if (pix_fire)
        remaining <= remaining - ONE;
    end
  end

  // R11
  accept_in_frame_chk: assert property (@(posedge clk) disable iff (rst) pix_fire |-> active)
    else $error("pixel accepted past the frame count");

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) frame_done |-> !active)
    else $error("frame_done while the frame still takes pixels");

endmodule

// File: rtl/pxpk_emit.sv
module pxpk_emit
  import pxpk_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int PIX_W = 24,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [1:0]       lines_code,
  input  fmt_e             fmt,
  input  logic             pix_fire,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             pix_last,
  input  logic             word_ready,
  output logic             can_load,
  output logic             word_valid,
  output logic [BUS_W-1:0] word_data,
  output logic             tail_pop
);

  localparam int HALF_W = BUS_W / 2;
  localparam int CW     = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] C1 = CW'(1);
  localparam logic [CW-1:0] C2 = CW'(2);
  localparam logic [CW-1:0] C3 = CW'(3);

  logic [BUS_W-1:0]  q  [DEPTH];
  logic [BUS_W-1:0]  nq [DEPTH];
  logic [CW-1:0]     cnt, ncnt;
  logic              phase, nphase;
  logic [HALF_W-1:0] low_q, nlow, low_n;
  logic              tail;
  logic              pop;

  logic [4:0]  nl, nh;
  logic [31:0] mf, mh, px;
  logic [BUS_W-1:0] s_lo, s_mid, s_top, a_top, join_w, pad_w;

  // Slice extraction: shifts are chosen by the latched bus width.
  always_comb begin
    case (lines_code)
      2'd0:    nl = 5'd8;
      2'd1:    nl = 5'd9;
      2'd2:    nl = 5'd12;
      default: nl = 5'd16;
    endcase
    nh     = nl >> 1;
    mf     = (32'd1 << nl) - 32'd1;
    mh     = (32'd1 << nh) - 32'd1;
    px     = 32'(pix_data);
    s_lo   = BUS_W'(px & mf);
    s_mid  = BUS_W'((px >> nl) & mf);
    s_top  = BUS_W'((px >> {nl, 1'b0}) & mf);
    a_top  = BUS_W'((px >> nh) & mf);
    low_n  = HALF_W'(px & mh);
    join_w = BUS_W'((32'(low_q) << nh) | ((px >> nl) & mh));
    pad_w  = BUS_W'(32'(low_n) << nh);
  end

  // Words produced by one accepted pixel.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) nq[i] = '0;
    ncnt   = '0;
    nphase = phase;
    nlow   = low_q;
    case (fmt)
      FMT_ONE: begin
        nq[0] = s_lo;
        ncnt  = C1;
      end
      FMT_TWO: begin
        nq[0] = s_mid;
        nq[1] = s_lo;
        ncnt  = C2;
      end
      FMT_THREE: begin
        nq[0] = s_top;
        nq[1] = s_mid;
        nq[2] = s_lo;
        ncnt  = C3;
      end
      default: begin
        if (!phase) begin
          nq[0] = a_top;
          nlow  = low_n;
          if (pix_last) begin
            nq[1]  = pad_w;
            ncnt   = C2;
            nphase = 1'b0;
          end else begin
            ncnt   = C1;
            nphase = 1'b1;
          end
        end else begin
          nq[0]  = join_w;
          nq[1]  = s_lo;
          ncnt   = C2;
          nphase = 1'b0;
        end
      end
    endcase
  end

  always_comb begin
    word_valid = (cnt != '0);
    word_data  = q[0];
    pop        = word_valid && word_ready;
    can_load   = (cnt == '0) || ((cnt == C1) && word_ready);
    tail_pop   = pop && (cnt == C1) && tail && !flush;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      phase <= 1'b0;
      low_q <= '0;
      tail  <= 1'b0;
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else if (flush) begin
      cnt   <= '0;
      phase <= 1'b0;
      tail  <= 1'b0;
    end else if (pix_fire) begin
      for (int i = 0; i < DEPTH; i++) q[i] <= nq[i];
      cnt   <= ncnt;
      phase <= nphase;
      low_q <= nlow;
      tail  <= pix_last;
    end else if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) q[i] <= q[i+1];
      q[DEPTH-1] <= '0;
      cnt        <= cnt - C1;
    end
  end

  // R9
  hold_word_chk: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !word_ready && !flush) |=> (word_valid && $stable(word_data)))
    else $error("stalled word changed or vanished");

  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> ((32'(word_data) & ~mf) == 32'd0))
    else $error("word bits above the bus width are set");

endmodule

// File: rtl/pixel_bus_packer.sv
module pixel_bus_packer
  import pxpk_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int PIX_W = 24,
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_dtype,
  input  logic [1:0]       cfg_lines,
  input  logic [1:0]       cfg_fmt,
  input  logic [CNT_W-1:0] frame_pixels,
  input  logic             frame_start,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  output logic             pix_ready,
  output logic             word_valid,
  output logic [BUS_W-1:0] word_data,
  input  logic             word_ready,
  output logic             frame_done,
  output logic             cfg_err
);

  logic       start_ok;
  logic [1:0] lat_lines;
  fmt_e       lat_fmt;
  logic       active, last_pix, can_load, tail_pop, pix_fire;

  pxpk_cfg u_cfg (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .cfg_dtype   (cfg_dtype),
    .cfg_lines   (cfg_lines),
    .cfg_fmt     (cfg_fmt),
    .start_ok    (start_ok),
    .lat_lines   (lat_lines),
    .lat_fmt     (lat_fmt),
    .cfg_err     (cfg_err)
  );

  pxpk_frame #(.CNT_W(CNT_W)) u_frame (
    .clk          (clk),
    .rst          (rst),
    .start_ok     (start_ok),
    .frame_pixels (frame_pixels),
    .pix_fire     (pix_fire),
    .tail_pop     (tail_pop),
    .active       (active),
    .last_pix     (last_pix),
    .frame_done   (frame_done)
  );

  pxpk_emit #(.BUS_W(BUS_W), .PIX_W(PIX_W)) u_emit (
    .clk        (clk),
    .rst        (rst),
    .flush      (start_ok),
    .lines_code (lat_lines),
    .fmt        (lat_fmt),
    .pix_fire   (pix_fire),
    .pix_data   (pix_data),
    .pix_last   (last_pix),
    .word_ready (word_ready),
    .can_load   (can_load),
    .word_valid (word_valid),
    .word_data  (word_data),
    .tail_pop   (tail_pop)
  );

  always_comb begin
    pix_ready = active && can_load && !frame_start;
    pix_fire  = pix_valid && pix_ready;
  end

  // R10
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !word_ready) |-> !pix_ready)
    else $error("pixel taken while a word is stalled");

endmodule

// File: tb/pixel_bus_packer_tb_top.sv
`timescale 1ns/1ps
module pixel_bus_packer_tb_top;

  localparam int CNT_W = 22;
  localparam int WD_LIMIT = 150000;

  logic             clk = 1'b0;
  logic             rst;
  logic [1:0]       cfg_dtype, cfg_lines, cfg_fmt;
  logic [CNT_W-1:0] frame_pixels;
  logic             frame_start, pix_valid, pix_ready;
  logic [23:0]      pix_data;
  logic             word_valid, word_ready, frame_done, cfg_err;
  logic [15:0]      word_data;

  always #2.5 clk = ~clk;

  pixel_bus_packer dut_i (
    .clk(clk), .rst(rst), .cfg_dtype(cfg_dtype), .cfg_lines(cfg_lines), .cfg_fmt(cfg_fmt),
    .frame_pixels(frame_pixels), .frame_start(frame_start), .pix_valid(pix_valid),
    .pix_data(pix_data), .pix_ready(pix_ready), .word_valid(word_valid), .word_data(word_data),
    .word_ready(word_ready), .frame_done(frame_done), .cfg_err(cfg_err)
  );

  int checks = 0, fails = 0, cyc = 0;

  // Behavioural model state
  int    exp_q[$];
  bit    last_q[$];
  string tag_q[$];
  int    m_n = 0, m_sent = 0, m_bits = 12, m_l = 8, m_f = 0;
  bit    m_err = 0, m_havea = 0, done_exp = 0, flood = 0;
  int    m_alow = 0;
  string tag_over = "";
  bit    hold_prev = 0, prev_start = 0;
  int    prev_data = 0;

  function automatic int bits_of(int code);
    return (code == 0) ? 12 : (code == 1) ? 16 : (code == 2) ? 18 : 24;
  endfunction
  function automatic int lines_of(int code);
    return (code == 0) ? 8 : (code == 1) ? 9 : (code == 2) ? 12 : 16;
  endfunction
  function automatic int want_fmt(int b, int l);
    if (b % l == 0 && b / l >= 1 && b / l <= 3) return b / l - 1;
    if ((2 * b) % l == 0 && (2 * b) / l == 3) return 3;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic put(input int w, input bit last, input string t);
    exp_q.push_back(w);
    last_q.push_back(last);
    tag_q.push_back(tag_over != "" ? tag_over : t);
  endtask

  task automatic model_pixel(input int p);
    int pm, mask, h, hmask, n;
    bit islast;
    islast = (m_sent == m_n - 1);
    pm    = p & ((1 << m_bits) - 1);
    mask  = (1 << m_l) - 1;
    h     = m_l / 2;
    hmask = (1 << h) - 1;
    if (m_f < 3) begin
      n = m_f + 1;
      for (int k = 0; k < n; k++)
        put((pm >> (m_bits - (k + 1) * m_l)) & mask, islast && (k == n - 1), (m_f == 0) ? "R4 word" : "R5 word");
    end else if (!m_havea) begin
      put((pm >> h) & mask, 1'b0, "R6 word");
      if (islast) put((pm & hmask) << h, 1'b1, "R7 pad word");
      else begin m_alow = pm & hmask; m_havea = 1; end
    end else begin
      put((m_alow << h) | ((pm >> m_l) & hmask), 1'b0, "R6 word");
      put(pm & mask, islast, "R6 word");
      m_havea = 0;
    end
    m_sent++;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic step(input bit start, input int rdy_pct, input int vld_pct);
    bit exp_rdy;
    int b, l;
    @(negedge clk);
    cyc++;
    if (cyc > WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, WD_LIMIT);
      summary();
      $finish;
    end
    frame_start = start;
    word_ready  = ($urandom_range(99) < rdy_pct);
    pix_valid   = ((m_sent < m_n) || flood) && ($urandom_range(99) < vld_pct);
    pix_data    = 24'($urandom);
    #0.5;
    chk(frame_done == done_exp, "R11 frame_done", frame_done, done_exp);
    done_exp = 0;
    chk(cfg_err == m_err, "R3 cfg_err", cfg_err, m_err);
    exp_rdy = !start && (m_sent < m_n) && (exp_q.size() == 0 || (exp_q.size() == 1 && word_ready));
    chk(pix_ready == exp_rdy, "R10 pix_ready", pix_ready, exp_rdy);
    chk(word_valid == (exp_q.size() != 0), "R10 word_valid", word_valid, exp_q.size() != 0);
    if (hold_prev && !prev_start)
      chk(word_valid && word_data == 16'(prev_data), "R9 stalled word", word_data, prev_data);
    if (word_valid && word_ready && exp_q.size() > 0) begin
      chk(int'(word_data) == exp_q[0], tag_q[0], word_data, exp_q[0]);
      chk((int'(word_data) >> m_l) == 0, "R8 upper bits", word_data, 0);
      if (last_q[0]) done_exp = 1;
      void'(exp_q.pop_front());
      void'(last_q.pop_front());
      void'(tag_q.pop_front());
    end
    hold_prev  = word_valid && !word_ready;
    prev_data  = word_data;
    prev_start = start;
    if (pix_valid && pix_ready) model_pixel(pix_data);
    if (start) begin
      b = bits_of(cfg_dtype);
      l = lines_of(cfg_lines);
      if (want_fmt(b, l) == int'(cfg_fmt)) begin
        exp_q.delete(); last_q.delete(); tag_q.delete();
        m_bits = b; m_l = l; m_f = cfg_fmt;
        m_n = frame_pixels; m_sent = 0; m_havea = 0;
        done_exp = (frame_pixels == 0);
      end else begin
        m_err = 1;
      end
    end
  endtask

  task automatic run_frame(input int d, input int w, input int f, input int n,
                           input int rdy_pct, input int vld_pct, input int abort_after,
                           input bit scramble, input string tag);
    cfg_dtype = 2'(d); cfg_lines = 2'(w); cfg_fmt = 2'(f);
    frame_pixels = CNT_W'(n);
    tag_over = tag;
    step(1'b1, rdy_pct, vld_pct);
    for (int k = 0; k < 5000; k++) begin
      if (abort_after >= 0 && k == abort_after) return;
      if (scramble && k == 3) begin
        cfg_dtype = ~cfg_dtype; cfg_lines = ~cfg_lines; cfg_fmt = ~cfg_fmt;
      end
      if (k >= 8 && m_sent >= m_n && exp_q.size() == 0 && !done_exp) break;
      step(1'b0, rdy_pct, vld_pct);
    end
    step(1'b0, rdy_pct, vld_pct);
    tag_over = "";
  endtask

  initial begin
    rst = 1'b1; frame_start = 0; pix_valid = 0; pix_data = '0; word_ready = 0;
    cfg_dtype = 0; cfg_lines = 0; cfg_fmt = 0; frame_pixels = '0;
    repeat (4) @(negedge clk);
    #0.5;
    chk(!word_valid && !pix_ready && !frame_done && !cfg_err, "R1 outputs in reset",
        {word_valid, pix_ready, frame_done, cfg_err}, 0);
    @(negedge clk);
    rst = 1'b0;
    step(1'b0, 100, 0);
    chk(!word_valid && !pix_ready && !frame_done && !cfg_err, "R1 outputs after reset",
        {word_valid, pix_ready, frame_done, cfg_err}, 0);

    // R4: one word per pixel
    run_frame(0, 2, 0, 10, 100, 100, -1, 0, "");
    run_frame(1, 3, 0, 12, 60, 80, -1, 0, "");
    // R5: two and three words per pixel, MS slice first
    run_frame(1, 0, 1, 9, 70, 90, -1, 0, "");
    run_frame(2, 1, 1, 7, 50, 70, -1, 0, "");
    run_frame(3, 2, 1, 8, 100, 100, -1, 0, "");
    run_frame(3, 0, 2, 11, 40, 100, -1, 0, "");
    // R6 / R7: three words per two pixels, even and odd counts
    run_frame(0, 0, 3, 6, 100, 100, -1, 0, "");
    run_frame(3, 3, 3, 5, 60, 80, -1, 0, "");
    run_frame(2, 2, 3, 3, 30, 60, -1, 0, "");
    run_frame(0, 0, 3, 1, 100, 100, -1, 0, "");
    // R11: zero-count frame
    run_frame(1, 3, 0, 0, 100, 100, -1, 0, "");
    // R2: configuration changes mid-frame are ignored
    run_frame(3, 0, 2, 6, 80, 90, -1, 1, "R2 word");
    // R3: illegal pair and mismatched format, with pixels offered
    flood = 1;
    run_frame(2, 0, 0, 5, 100, 100, -1, 0, "");
    run_frame(1, 0, 0, 5, 100, 100, -1, 0, "");
    flood = 0;
    run_frame(1, 3, 0, 4, 100, 100, -1, 0, "R3 word after error");
    // R12: restart during a stalled frame
    run_frame(3, 0, 2, 20, 20, 100, 10, 0, "");
    run_frame(1, 3, 0, 4, 100, 100, -1, 0, "R12 word after restart");
    run_frame(0, 0, 3, 7, 50, 50, 6, 0, "");
    run_frame(3, 3, 3, 4, 70, 100, -1, 0, "R12 word after restart");
    // long mixed run
    run_frame(3, 2, 1, 200, 75, 75, -1, 0, "");
    summary();
    $finish;
  end

endmodule